// File: doc/BRIEF.md
# Five-Stage Interlocked Instruction Pipeline

This block is an in-order processor pipeline with five stages: fetch, decode, operand-address generation, operand fetch and execute. Each instruction carries its own decoded fields, immediate, branch target and operand values in the register of the stage it occupies. Every hazard is resolved by an interlock and never by forwarding or prediction. A register read after an unfinished write stalls the reader. A conditional branch stops fetch from the moment it is decoded until it has executed. A multiply or divide holds the execute stage, and every older stage behind it, for its full latency.

A small register file, a single-cycle ALU, an iterative-latency multiply/divide path and a synchronous instruction memory are included so that the pipeline can be exercised end to end. The program is written through a load port while reset is held. Results are observed on a retirement port that reports each instruction as it leaves execute.

Top module: `pipe5_core`

## Requirements
- R1: While rst_n is low, retire_valid and div_zero_flag are 0. After release, with no hazards, the first instruction is reported on retire_valid in the cycle that follows the fourth rising edge.
- R2: Instruction word fields: [15:12] opcode, [11:9] destination, [8:6] first source, [5:3] second source, [5:0] signed 6-bit immediate, [8:0] unsigned 9-bit immediate. Opcodes: 0 no-op, 1 add, 2 subtract (first minus second), 3 and, 4 or, 5 add signed immediate to first source, 6 multiply, 7 divide, 8 branch if first source non-zero, 9 load unsigned 9-bit immediate. Opcodes 10 to 15 act as no-ops. Results are 16 bits wide and are written to the destination register.
- R3: Instructions retire in program order. Independent single-cycle instructions retire one per cycle.
- R4: When the instruction in operand fetch reads a register that the instruction in execute will write, one bubble is inserted, so the reader retires two cycles after the writer. Instructions that are two or more apart do not stall.
- R5: Multiply returns the low 16 bits of the product and occupies execute for 4 cycles. Younger instructions and the fetch address are held during that time, even when they are independent.
- R6: Divide returns the unsigned quotient and occupies execute for 8 cycles.
- R7: Divide by zero writes 0xFFFF and sets div_zero_flag, starting in the cycle after the divide retires. The flag then stays set until reset.
- R8: No instruction is fetched after a branch is decoded until the branch executes. A taken branch continues at its own address plus the signed immediate. A branch that is not taken continues at the next address. Either way, the next instruction retires exactly 5 cycles after the branch.
- R9: Words written through the load port while in reset form the program, and fetch starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_waddr | input | ADDR_W | Instruction memory write address |
| imem_wdata | input | 16 | Instruction word to store |
| retire_valid | output | 1 | An instruction leaves execute this cycle |
| retire_pc | output | ADDR_W | Address of the retiring instruction |
| retire_we | output | 1 | Retiring instruction writes a register |
| retire_rd | output | 3 | Destination register of the retiring instruction |
| retire_data | output | DATA_W | Result of the retiring instruction |
| div_zero_flag | output | 1 | Sticky divide-by-zero indication |

## Verification
The first program mixes independent loads, back-to-back dependent pairs, a dependent multiply, a divide, a divide by zero and a two-pass backward loop. This separates one-per-cycle flow from the one-bubble interlock, and a taken branch from one that is not taken. The second program places independent instructions behind a multiply and a divide, so a design that overlapped them with the long operation would retire early. Every retirement is compared with a behavioural instruction-level model for address, destination and value, and selected retirements are also checked against hand-derived cycle numbers that pin down each stall length.

// File: rtl/pipe5_pkg.sv
// Shared encodings for the five-stage pipeline.
// Assumes a 16-bit instruction word and eight architectural registers.
package pipe5_pkg;
    localparam int INSTR_W = 16;
    localparam int REG_AW  = 3;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_ADDI = 4'd5,
        OP_MUL  = 4'd6,
        OP_DIV  = 4'd7,
        OP_BNZ  = 4'd8,
        OP_LI   = 4'd9
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic              use1;
        logic              use2;
        logic              wr;
        logic [8:0]        imm;
    } dec_t;
endpackage

// File: rtl/pipe5_imem.sv
// Synchronous instruction store: one write port for loading, one registered read port.
// Assumes the read data register holds its value while no read is issued.
module pipe5_imem #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store words from the load port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read, updated only when fetch issues.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/pipe5_decode.sv
// Combinational instruction decoder: splits fields and marks register use.
// Assumes opcodes outside the defined set behave as no-ops.
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    // Field split and per-opcode register usage.
    always_comb begin
        dec      = '0;
        dec.rd   = instr[11:9];
        dec.rs1  = instr[8:6];
        dec.rs2  = instr[5:3];
        dec.imm  = instr[8:0];
        dec.op   = OP_NOP;
        case (instr[15:12])
            4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7: begin
                dec.op   = op_e'(instr[15:12]);
                dec.use1 = 1'b1;
                dec.use2 = 1'b1;
                dec.wr   = 1'b1;
            end
            4'd5: begin
                dec.op   = OP_ADDI;
                dec.use1 = 1'b1;
                dec.wr   = 1'b1;
            end
            4'd8: begin
                dec.op   = OP_BNZ;
                dec.use1 = 1'b1;
            end
            4'd9: begin
                dec.op   = OP_LI;
                dec.wr   = 1'b1;
            end
            default: dec.op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/pipe5_regfile.sv
// Register file with two combinational read ports and one write port.
// Assumes the write lands at the clock edge that ends the writer's execute cycle.
module pipe5_regfile #(
    parameter int DATA_W = 16,
    parameter int RAW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW-1:0]    ra1,
    input  logic [RAW-1:0]    ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2,
    input  logic              we,
    input  logic [RAW-1:0]    wa,
    input  logic [DATA_W-1:0] wd
);
    localparam int NREG = 1 << RAW;

    logic [DATA_W-1:0] regs [NREG];

    // Clear on reset, otherwise accept the retiring result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/pipe5_exec.sv
// Execute unit: single-cycle ALU plus fixed-latency multiply and divide.
// Assumes operands stay stable in the stage register while busy is high.
module pipe5_exec
    import pipe5_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] imm,
    output logic              busy,
    output logic              taken,
    output logic              div_zero,
    output logic [DATA_W-1:0] result
);
    localparam int MAX_CYC = (DIV_CYC > MUL_CYC) ? DIV_CYC : MUL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             long_op;

    assign long_op  = valid && (op == OP_MUL || op == OP_DIV);
    assign last     = (op == OP_MUL) ? CNT_W'(MUL_CYC - 1) : CNT_W'(DIV_CYC - 1);
    assign busy     = long_op && (cnt != last);
    assign taken    = valid && (op == OP_BNZ) && (a != '0);
    assign div_zero = (op == OP_DIV) && (b == '0);

    // Count cycles spent on a long operation; idle at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (busy) cnt <= cnt + 1'b1;
        else           cnt <= '0;
    end

    // Result selection per operation.
    always_comb begin
        case (op)
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_ADDI: result = a + imm;
            OP_MUL:  result = a * b;
            OP_DIV:  result = div_zero ? '1 : a / b;
            OP_LI:   result = imm;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order pipeline: fetch, decode, address generation, operand fetch, execute.
// Assumes all hazards are resolved by interlock; there is no forwarding or prediction.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [ADDR_W-1:0]  imem_waddr,
    input  logic [INSTR_W-1:0] imem_wdata,
    output logic               retire_valid,
    output logic [ADDR_W-1:0]  retire_pc,
    output logic               retire_we,
    output logic [REG_AW-1:0]  retire_rd,
    output logic [DATA_W-1:0]  retire_data,
    output logic               div_zero_flag
);
    logic [ADDR_W-1:0]  pc;
    logic [INSTR_W-1:0] fd_instr;
    logic               fd_valid, da_valid, ao_valid, ox_valid;
    logic [ADDR_W-1:0]  fd_pc, da_pc, ao_pc, ox_pc;
    dec_t               fd_dec, da_dec, ao_dec;
    logic [DATA_W-1:0]  ao_imm, ox_imm, ox_a, ox_b;
    logic [ADDR_W-1:0]  ao_target, ox_target;
    op_e                ox_op;
    logic [REG_AW-1:0]  ox_rd;
    logic               ox_wr;

    logic               x_busy, x_taken, x_div0, x_done;
    logic [DATA_W-1:0]  x_result, rf_a, rf_b;
    logic               hazard, stall, branch_hold, fetch_issue;
    logic signed [5:0]  off6;

    assign off6        = $signed(da_dec.imm[5:0]);
    assign x_done      = ox_valid && !x_busy;
    assign hazard      = ao_valid && ox_valid && ox_wr &&
                         ((ao_dec.use1 && ao_dec.rs1 == ox_rd) ||
                          (ao_dec.use2 && ao_dec.rs2 == ox_rd));
    assign stall       = x_busy || hazard;
    assign branch_hold = (fd_valid && fd_dec.op == OP_BNZ) || (da_valid && da_dec.op == OP_BNZ) ||
                         (ao_valid && ao_dec.op == OP_BNZ) || (ox_valid && ox_op == OP_BNZ);
    assign fetch_issue = !stall && !branch_hold;

    pipe5_imem #(.ADDR_W(ADDR_W), .WORD_W(INSTR_W)) u_imem (
        .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
        .re(fetch_issue), .raddr(pc), .rdata(fd_instr)
    );

    pipe5_decode u_decode (.instr(fd_instr), .dec(fd_dec));

    pipe5_regfile #(.DATA_W(DATA_W), .RAW(REG_AW)) u_rf (
        .clk(clk), .rst_n(rst_n), .ra1(ao_dec.rs1), .ra2(ao_dec.rs2),
        .rd1(rf_a), .rd2(rf_b), .we(x_done && ox_wr), .wa(ox_rd), .wd(x_result)
    );

    pipe5_exec #(.DATA_W(DATA_W), .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) u_exec (
        .clk(clk), .rst_n(rst_n), .valid(ox_valid), .op(ox_op), .a(ox_a), .b(ox_b),
        .imm(ox_imm), .busy(x_busy), .taken(x_taken), .div_zero(x_div0), .result(x_result)
    );

    // Fetch address: redirect on a taken branch, otherwise step when fetch issues.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc <= '0;
        else if (x_done && x_taken) pc <= ox_target;
        else if (fetch_issue)       pc <= pc + 1'b1;
    end

    // Fetch, decode and address-generation registers advance together unless stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd_valid <= 1'b0;
            da_valid <= 1'b0;
            ao_valid <= 1'b0;
        end else if (!stall) begin
            fd_valid <= fetch_issue;
            da_valid <= fd_valid;
            ao_valid <= da_valid;
        end
    end

    // Payload of the front three stages; held with the valid bits.
    always_ff @(posedge clk) begin
        if (!stall) begin
            fd_pc     <= pc;
            da_pc     <= fd_pc;
            da_dec    <= fd_dec;
            ao_pc     <= da_pc;
            ao_dec    <= da_dec;
            ao_imm    <= (da_dec.op == OP_LI) ? DATA_W'(da_dec.imm) : DATA_W'(off6);
            ao_target <= da_pc + ADDR_W'(off6);
        end
    end

    // Operand fetch into execute; a hazard turns the slot into a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n)       ox_valid <= 1'b0;
        else if (!x_busy) ox_valid <= ao_valid && !hazard;
    end

    // Execute payload; frozen while a long operation is in progress.
    always_ff @(posedge clk) begin
        if (!x_busy) begin
            ox_pc     <= ao_pc;
            ox_op     <= ao_dec.op;
            ox_rd     <= ao_dec.rd;
            ox_wr     <= ao_dec.wr;
            ox_a      <= rf_a;
            ox_b      <= rf_b;
            ox_imm    <= ao_imm;
            ox_target <= ao_target;
        end
    end

    // Sticky divide-by-zero indication.
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_zero_flag <= 1'b0;
        else if (x_done && x_div0)  div_zero_flag <= 1'b1;
    end

    assign retire_valid = x_done;
    assign retire_pc    = ox_pc;
    assign retire_we    = ox_wr;
    assign retire_rd    = ox_rd;
    assign retire_data  = x_result;
endmodule

// File: rtl/pipe5_core_chk.sv
// Property checker for the pipeline, attached by bind.
// Assumes visibility of the execute-stage and fetch control signals.
module pipe5_core_chk
    import pipe5_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              x_busy,
    input logic              hazard,
    input logic              ox_valid,
    input op_e               ox_op,
    input logic [ADDR_W-1:0] pc,
    input logic              retire_valid,
    input logic              div_zero_flag
);
    localparam int MAX_CYC = (DIV_CYC > MUL_CYC) ? DIV_CYC : MUL_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] hold_cnt;

    // Independent count of cycles an execute slot stays occupied before retiring.
    always_ff @(posedge clk) begin
        if (!rst_n)            hold_cnt <= '0;
        else if (retire_valid) hold_cnt <= '0;
        else if (x_busy)       hold_cnt <= hold_cnt + 1'b1;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_flag |=> div_zero_flag); // R7

    AST_HAZARD_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard && !x_busy) |=> !retire_valid); // R4

    AST_BUSY_FREEZES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        x_busy |=> $stable(pc)); // R5

    AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && ox_op == OP_MUL) |-> hold_cnt == CW'(MUL_CYC - 1)); // R5

    AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && ox_op == OP_DIV) |-> hold_cnt == CW'(DIV_CYC - 1)); // R6

    AST_BRANCH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && ox_op == OP_BNZ) |=> !ox_valid); // R8
endmodule

bind pipe5_core pipe5_core_chk #(.ADDR_W(ADDR_W), .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .x_busy(x_busy), .hazard(hazard), .ox_valid(ox_valid),
    .ox_op(ox_op), .pc(pc), .retire_valid(retire_valid), .div_zero_flag(div_zero_flag)
);

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_we = 1'b0;
    logic [AW-1:0] imem_waddr = '0;
    logic [15:0]   imem_wdata = '0;
    logic          retire_valid, retire_we, div_zero_flag;
    logic [AW-1:0] retire_pc;
    logic [2:0]    retire_rd;
    logic [DW-1:0] retire_data;

    always #2.5 clk = ~clk;

    pipe5_core #(.ADDR_W(AW), .DATA_W(DW)) u_pipe5_core (
        .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .retire_valid(retire_valid), .retire_pc(retire_pc),
        .retire_we(retire_we), .retire_rd(retire_rd), .retire_data(retire_data),
        .div_zero_flag(div_zero_flag)
    );

    int checks = 0;
    int failures = 0;
    logic [15:0] prog [64];
    logic [AW-1:0] q_pc[$];
    logic [2:0]    q_rd[$];
    logic [15:0]   q_data[$];
    logic [3:0]    q_op[$];
    bit            q_we[$];
    bit            q_z[$];
    int            exp_cyc[$];
    string         exp_tag[$];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [15:0] enc_r(int op, int rd, int s1, int s2);
        return {op[3:0], rd[2:0], s1[2:0], s2[2:0], 3'b000};
    endfunction

    function automatic logic [15:0] enc_i(int op, int rd, int s1, int imm);
        return {op[3:0], rd[2:0], s1[2:0], imm[5:0]};
    endfunction

    function automatic logic [15:0] enc_li(int rd, int v);
        return {4'd9, rd[2:0], v[8:0]};
    endfunction

    // Instruction-level reference: executes the program in order and queues retirements.
    task automatic build_ref(int n);
        logic [15:0] r [8];
        logic [AW-1:0] pcv = '0;
        for (int i = 0; i < 8; i++) r[i] = '0;
        q_pc.delete(); q_rd.delete(); q_data.delete(); q_op.delete(); q_we.delete(); q_z.delete();
        for (int k = 0; k < n; k++) begin
            logic [15:0] ins, a, b, sx, val;
            logic [3:0] op;
            bit we, z;
            logic [AW-1:0] npc;
            ins = prog[pcv];
            op  = ins[15:12];
            a   = r[ins[8:6]];
            b   = r[ins[5:3]];
            sx  = {{10{ins[5]}}, ins[5:0]};
            val = '0; we = 1'b1; z = 1'b0;
            npc = pcv + 1'b1;
            case (op)
                4'd1: val = a + b;
                4'd2: val = a - b;
                4'd3: val = a & b;
                4'd4: val = a | b;
                4'd5: val = a + sx;
                4'd6: val = a * b;
                4'd7: begin
                    if (b == 0) begin val = 16'hFFFF; z = 1'b1; end
                    else val = a / b;
                end
                4'd8: begin we = 1'b0; if (a != 0) npc = pcv + ins[5:0]; end
                4'd9: val = {7'd0, ins[8:0]};
                default: we = 1'b0;
            endcase
            if (we) r[ins[11:9]] = val;
            q_pc.push_back(pcv); q_rd.push_back(ins[11:9]); q_data.push_back(val);
            q_op.push_back(op); q_we.push_back(we); q_z.push_back(z);
            pcv = npc;
        end
    endtask

    // Hold reset, load the program through the write port, check reset outputs, release.
    task automatic load_and_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            imem_we = 1'b1; imem_waddr = AW'(i); imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        chk(retire_valid == 1'b0, "R1", "retire_valid in reset", retire_valid, 0);
        chk(div_zero_flag == 1'b0, "R1", "div flag in reset", div_zero_flag, 0);
        rst_n = 1'b1;
    endtask

    // Compare every clock against the reference queue and the expected retire cycles.
    task automatic run_prog(int n);
        int cyc = 0;
        int idx = 0;
        bit ref_flag = 1'b0;
        logic [3:0] prev_op = 4'd0;
        while (idx < n && cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            chk(div_zero_flag == ref_flag, "R7", "div flag", div_zero_flag, ref_flag);
            if (retire_valid) begin
                logic [AW-1:0] e_pc = q_pc.pop_front();
                logic [2:0]    e_rd = q_rd.pop_front();
                logic [15:0]   e_dt = q_data.pop_front();
                logic [3:0]    e_op = q_op.pop_front();
                bit            e_we = q_we.pop_front();
                bit            e_z  = q_z.pop_front();
                string tp = (idx == 0) ? "R9" : ((prev_op == 4'd8) ? "R8" : "R3");
                string td = (e_op == 4'd6) ? "R5" : (e_op == 4'd7) ? (e_z ? "R7" : "R6") : "R2";
                chk(retire_pc == e_pc, tp, "retire pc", retire_pc, e_pc);
                chk(retire_we == e_we, "R2", "retire we", retire_we, e_we);
                if (e_we) begin
                    chk(retire_rd == e_rd, "R2", "retire rd", retire_rd, e_rd);
                    chk(retire_data == e_dt, td, "retire data", retire_data, e_dt);
                end
                if (idx < exp_cyc.size())
                    chk(cyc == exp_cyc[idx], exp_tag[idx], "retire cycle", cyc, exp_cyc[idx]);
                if (e_z) ref_flag = 1'b1;
                prev_op = e_op;
                idx++;
            end
        end
        chk(idx == n, "R3", "retire count", idx, n);
    endtask

    initial begin
        #1ms;
        checks++;
        failures++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // Program 1: dependences, multiply, divide, divide by zero, two-pass loop.
        for (int i = 0; i < 64; i++) prog[i] = '0;
        prog[0]  = enc_li(1, 5);
        prog[1]  = enc_li(2, 7);
        prog[2]  = enc_li(3, 3);
        prog[3]  = enc_r(1, 4, 1, 2);
        prog[4]  = enc_r(2, 5, 4, 3);
        prog[5]  = enc_r(6, 6, 5, 2);
        prog[6]  = enc_r(1, 7, 6, 1);
        prog[7]  = enc_r(7, 1, 6, 3);
        prog[8]  = enc_li(0, 0);
        prog[9]  = enc_r(7, 2, 7, 0);
        prog[10] = enc_li(3, 2);
        prog[11] = enc_i(5, 3, 3, -1);
        prog[12] = enc_i(8, 0, 3, -1);
        prog[13] = enc_r(3, 4, 1, 2);
        prog[14] = enc_r(4, 5, 4, 3);
        exp_cyc = '{4, 5, 6, 7, 9, 14, 16, 24, 25, 34, 35, 37, 39, 44, 46, 51, 53};
        exp_tag = '{"R1", "R3", "R3", "R3", "R4", "R5", "R5", "R6", "R6", "R6",
                    "R3", "R4", "R4", "R8", "R4", "R8", "R4"};
        build_ref(24);
        load_and_reset();
        run_prog(24);

        // Program 2: independent work behind long operations; reset clears the flag.
        for (int i = 0; i < 64; i++) prog[i] = '0;
        prog[0] = enc_li(1, 6);
        prog[1] = enc_li(2, 4);
        prog[3] = enc_r(6, 3, 1, 2);
        prog[4] = enc_r(1, 4, 1, 1);
        prog[5] = enc_r(7, 5, 1, 2);
        prog[6] = enc_r(1, 6, 1, 2);
        exp_cyc = '{4, 5, 6, 10, 11, 19, 20};
        exp_tag = '{"R1", "R3", "R3", "R5", "R5", "R6", "R6"};
        build_ref(10);
        load_and_reset();
        run_prog(10);

        finish_run();
    end
endmodule